// File: doc/BRIEF.md
# Trigger Latency Pipeline with Event Buffer

This block sits behind a free-running multi-channel ADC front end. On every clock it takes one sample word per channel and writes it into a circular delay memory. A level-1 accept arrives some fixed number of sample clocks after the interesting samples were taken. On an accept, the block copies a window of consecutive delayed samples for every channel into a free event slot. Several accepts can therefore be held while a readout path drains them.

The delay back in time comes from a latency register. The register may only be rewritten while no window copy is in flight. Rewriting it discards every held event, so that events taken under different latencies are never mixed. A busy output reports that every slot is occupied. An accept that finds no free slot is lost and sets a sticky overflow flag. The readout side presents one sample per word on a valid/ready stream. Events come out oldest first, then by channel, then by sample within the channel.

With the default parameters the block serves 48 channels of 12-bit samples. It uses a 256-entry delay memory, latencies from 1 to 240 samples, 12-sample windows and 8 event slots. The delay memory depth must be a power of two and larger than the largest latency.

Top module: `tlp_trigger_pipe`

## Requirements
- R1: After reset, out_valid, busy and overflow are low and the latency is DEF_LAT.
- R2: The sample bus is written into the delay memory on every clock. An accept sampled on the same edge as sample n captures, for each channel, samples n-L through n-L+WIN-1, where L is the current latency (1..MAXLAT).
- R3: Each event is read out as NCH*WIN words. The words run channel 0 to NCH-1, and within a channel sample 0 to WIN-1. Channel c occupies bits [c*SW +: SW] of the sample bus.
- R4: Events are read out in the order their accepts were taken. Accepts on consecutive or nearby clocks, whose windows overlap, are each captured in full. No word appears when no event is held.
- R5: busy is high from the edge on which the last free slot is taken until a slot is released.
- R6: An accept that arrives while all NSLOT slots are occupied is not captured. It sets overflow, which then stays high until reset.
- R7: While out_valid is high and out_ready is low, out_data holds its value. A slot is released only when its last word is transferred.
- R8: A latency write is taken only if no window copy is in progress and the value lies in 1..MAXLAT. Any other write leaves the latency unchanged.
- R9: A latency write that is taken discards every held event and drops out_valid and busy. An accept on the same edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | NCH*SW | One sample per channel, channel c at bits [c*SW +: SW] |
| l1_acc | input | 1 | Level-1 accept, one clock per accept |
| lat_we | input | 1 | Latency write strobe |
| lat_in | input | LATW | New latency in sample clocks |
| out_valid | output | 1 | Readout word valid |
| out_ready | input | 1 | Readout word taken when high with out_valid |
| out_data | output | SW | Readout sample |
| busy | output | 1 | All event slots occupied |
| overflow | output | 1 | Sticky: an accept was lost |

## Verification
The hardest state to reach is a full set of slots whose windows were still being copied while later accepts arrived. With that state in place the bench must also show a rejected accept, a stalled stream, and a latency rewrite that lands on top of pending events. The bench reaches it by holding out_ready low while it issues accepts two clocks apart, past the slot count. It then sends a rewrite together with a same-cycle accept while words are waiting. Every readout word is compared against the arithmetic sample pattern, indexed by the accept cycle and the latency the bench believes is in force. Any silent latency change or misplaced window therefore shows up as a data mismatch.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  // index width with a floor of one bit
  function automatic int unsigned idx_w(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tlp_delay_line.sv
module tlp_delay_line
  import tlp_pkg::*;
#(
  parameter int W     = 576,
  parameter int DEPTH = 256,
  parameter int LATW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    din,
  input  logic [LATW-1:0] lat,
  output logic [W-1:0]    dout
);
  localparam int AW = idx_w(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] ra;

  // read the entry written lat clocks ago; wraps because DEPTH is 2**AW
  assign ra = wp - AW'(lat);

  always_ff @(posedge clk) begin
    mem[wp] <= din;
    dout    <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (rst) wp <= '0;
    else     wp <= wp + 1'b1;
  end
endmodule

// File: rtl/tlp_slot_buf.sv
module tlp_slot_buf
  import tlp_pkg::*;
#(
  parameter int W   = 576,
  parameter int WIN = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   start,
  input  logic [W-1:0]           din,
  input  logic [idx_w(WIN)-1:0]  rd_idx,
  output logic                   active,
  output logic                   done,
  output logic [W-1:0]           rd_word
);
  localparam int IW = idx_w(WIN);

  logic [W-1:0]  mem [WIN];
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      done   <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (idx == IW'(WIN - 1)) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (active && !clr) mem[idx] <= din;
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/tlp_trigger_pipe.sv
module tlp_trigger_pipe
  import tlp_pkg::*;
#(
  parameter int NCH     = 48,
  parameter int SW      = 12,
  parameter int DEPTH   = 256,
  parameter int MAXLAT  = 240,
  parameter int WIN     = 12,
  parameter int NSLOT   = 8,
  parameter int DEF_LAT = 100,
  parameter int LATW    = $clog2(MAXLAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*SW-1:0] smp_in,
  input  logic              l1_acc,
  input  logic              lat_we,
  input  logic [LATW-1:0]   lat_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SW-1:0]     out_data,
  output logic              busy,
  output logic              overflow
);
  localparam int BW  = NCH * SW;
  localparam int SLW = idx_w(NSLOT);
  localparam int CW  = $clog2(NSLOT + 1);
  localparam int CHW = idx_w(NCH);
  localparam int KW  = idx_w(WIN);

  logic [LATW-1:0] lat_q;
  logic [BW-1:0]   dly_q;
  logic [NSLOT-1:0] s_start, s_clr, s_active, s_done;
  logic [BW-1:0]   s_word [NSLOT];
  logic [SLW-1:0]  ws, hs;
  logic [CW-1:0]   cnt, cnt_nxt;
  logic [CHW-1:0]  rch;
  logic [KW-1:0]   rk;
  logic            last_pend;
  logic            lat_ok, full, alloc, xfer, free_s, head_rdy, load, is_last;
  logic [BW-1:0]   head_word;
  logic [SW-1:0]   sel_word;

  tlp_delay_line #(.W(BW), .DEPTH(DEPTH), .LATW(LATW)) u_dly (
    .clk (clk),
    .rst (rst),
    .din (smp_in),
    .lat (lat_q),
    .dout(dly_q)
  );

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign s_start[s] = alloc && (ws == SLW'(s));
      assign s_clr[s]   = lat_ok || (free_s && (hs == SLW'(s)));
      tlp_slot_buf #(.W(BW), .WIN(WIN)) u_slot (
        .clk    (clk),
        .rst    (rst),
        .clr    (s_clr[s]),
        .start  (s_start[s]),
        .din    (dly_q),
        .rd_idx (rk),
        .active (s_active[s]),
        .done   (s_done[s]),
        .rd_word(s_word[s])
      );
    end
  endgenerate

  assign lat_ok   = lat_we && !(|s_active) && (lat_in != '0) &&
                    (int'(lat_in) <= MAXLAT);
  assign full     = (cnt == CW'(NSLOT));
  assign alloc    = l1_acc && !lat_ok && !full;
  assign xfer     = out_valid && out_ready;
  assign free_s   = xfer && last_pend;
  assign head_rdy = (cnt != '0) && s_done[hs];
  assign load     = head_rdy && !last_pend && (!out_valid || out_ready);
  assign is_last  = (rch == CHW'(NCH - 1)) && (rk == KW'(WIN - 1));
  assign head_word = s_word[hs];
  assign sel_word  = head_word[rch*SW +: SW];

  always_comb begin
    if (lat_ok) cnt_nxt = '0;
    else        cnt_nxt = cnt + CW'(alloc) - CW'(free_s);
  end

  function automatic logic [SLW-1:0] ring_inc(input logic [SLW-1:0] p);
    return (p == SLW'(NSLOT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q     <= LATW'(DEF_LAT);
      ws        <= '0;
      hs        <= '0;
      cnt       <= '0;
      rch       <= '0;
      rk        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      last_pend <= 1'b0;
      busy      <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      busy <= (cnt_nxt == CW'(NSLOT));
      if (l1_acc && !lat_ok && full) overflow <= 1'b1;
      if (lat_ok) begin
        lat_q     <= lat_in;
        ws        <= '0;
        hs        <= '0;
        cnt       <= '0;
        rch       <= '0;
        rk        <= '0;
        out_valid <= 1'b0;
        last_pend <= 1'b0;
      end else begin
        cnt <= cnt_nxt;
        if (alloc) ws <= ring_inc(ws);
        if (free_s) begin
          hs        <= ring_inc(hs);
          last_pend <= 1'b0;
        end
        if (load) begin
          out_data  <= sel_word;
          out_valid <= 1'b1;
          last_pend <= is_last;
          if (rk == KW'(WIN - 1)) begin
            rk  <= '0;
            rch <= is_last ? '0 : rch + 1'b1;
          end else begin
            rk <= rk + 1'b1;
          end
        end else if (xfer) begin
          out_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tlp_checker.sv
module tlp_checker #(
  parameter int SW   = 12,
  parameter int LATW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            l1_acc,
  input logic            lat_we,
  input logic            out_valid,
  input logic            out_ready,
  input logic [SW-1:0]   out_data,
  input logic            busy,
  input logic            overflow,
  input logic            lat_ok,
  input logic [LATW-1:0] lat_q
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !busy && !overflow));

  a_r5_busy_needs_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(l1_acc));

  a_r6_full_accept_flags: assert property (@(posedge clk) disable iff (rst)
    (busy && l1_acc && !lat_we) |=> overflow);

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !lat_ok) |=> (out_valid && $stable(out_data)));

  a_r8_rejected_write: assert property (@(posedge clk) disable iff (rst)
    (lat_we && !lat_ok) |=> $stable(lat_q));

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
    lat_ok |=> (!out_valid && !busy));
endmodule

bind tlp_trigger_pipe tlp_checker #(.SW(SW), .LATW(LATW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .l1_acc   (l1_acc),
  .lat_we   (lat_we),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .busy     (busy),
  .overflow (overflow),
  .lat_ok   (lat_ok),
  .lat_q    (lat_q)
);

// File: tb/test_tlp_trigger_pipe.sv
module test_tlp_trigger_pipe;
  localparam int NCH     = 3;
  localparam int SW      = 12;
  localparam int DEPTH   = 32;
  localparam int MAXLAT  = 24;
  localparam int WIN     = 4;
  localparam int NSLOT   = 3;
  localparam int DEF_LAT = 6;
  localparam int LATW    = $clog2(MAXLAT + 1);
  localparam int BW      = NCH * SW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [BW-1:0]   smp;
  logic            l1_acc = 1'b0;
  logic            lat_we = 1'b0;
  logic [LATW-1:0] lat_in = '0;
  logic            out_ready = 1'b0;
  logic            out_valid, busy, overflow;
  logic [SW-1:0]   out_data;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [SW-1:0] sval(int n, int c);
    return SW'((n * 37 + c * 101 + 5) & 4095);
  endfunction

  always_comb
    for (int c = 0; c < NCH; c++) smp[c*SW +: SW] = sval(cyc, c);

  tlp_trigger_pipe #(
    .NCH(NCH), .SW(SW), .DEPTH(DEPTH), .MAXLAT(MAXLAT), .WIN(WIN),
    .NSLOT(NSLOT), .DEF_LAT(DEF_LAT), .LATW(LATW)
  ) i_tlp_trigger_pipe (
    .clk(clk), .rst(rst), .smp_in(smp), .l1_acc(l1_acc), .lat_we(lat_we),
    .lat_in(lat_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .busy(busy), .overflow(overflow)
  );

  int total = 0, bad = 0;
  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // bench model of held events
  int eT [256];
  int eL [256];
  int head = 0, tail = 0, cur_lat = DEF_LAT, last_acc = -1000;
  int wch = 0, wk = 0, rmode = 0, expw = 0;
  string ptag = "R2";
  bit rdy;

  // readout collector: ready decided at negedge, word taken at next posedge
  always @(negedge clk) begin
    if (!rst) begin
      rdy = (rmode == 1) || (rmode == 2 && (cyc % 3) != 0);
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (head == tail) chk(1'b0, "R4 word with no event held", out_data, -1);
        else begin
          expw = sval(eT[head] - eL[head] + wk, wch);
          chk(out_data == SW'(expw), {"R2+R3+R4 word, phase ", ptag}, out_data, expw);
          wk++;
          if (wk == WIN) begin
            wk = 0;
            wch++;
            if (wch == NCH) begin
              wch = 0;
              head++;
            end
          end
        end
      end
    end
  end

  task automatic push_event();
    if (tail - head < NSLOT) begin
      eT[tail] = cyc;
      eL[tail] = cur_lat;
      tail++;
      last_acc = cyc;
    end
  endtask

  task automatic acc();
    @(negedge clk);
    l1_acc = 1'b1;
    push_event();
    @(negedge clk);
    l1_acc = 1'b0;
  endtask

  task automatic setlat(int v, bit with_acc);
    @(negedge clk);
    lat_we = 1'b1;
    lat_in = LATW'(v);
    l1_acc = with_acc;
    if (cyc > last_acc + WIN && v >= 1 && v <= MAXLAT) begin
      cur_lat = v;
      head = tail;
      wch = 0;
      wk = 0;
    end else if (with_acc) begin
      push_event();
    end
    @(negedge clk);
    lat_we = 1'b0;
    l1_acc = 1'b0;
  endtask

  task automatic drain(int mode);
    rmode = mode;
    for (int i = 0; i < 3000 && head != tail; i++) @(negedge clk);
    chk(head == tail, "R4 all events drained", tail - head, 0);
    repeat (4) @(negedge clk);
    rmode = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 stream idle after drain", out_valid, 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  logic [SW-1:0] held;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
    repeat (40) @(negedge clk);

    // R1 default latency used by the first event
    ptag = "R1 default latency";
    acc();
    drain(1);

    // R2 latency sweep including both ends
    foreach (eL[i]) if (i < 1) ; // keeps loop form simple for tools
    for (int j = 0; j < 5; j++) begin
      int lv;
      lv = (j == 0) ? 1 : (j == 1) ? 5 : (j == 2) ? 13 : (j == 3) ? 20 : MAXLAT;
      setlat(lv, 1'b0);
      repeat (30) @(negedge clk);
      ptag = "R2 latency sweep";
      acc();
      drain((j % 2) + 1);
    end

    // R4 accepts on consecutive clocks and two apart
    ptag = "R4 overlapping windows";
    @(negedge clk);
    l1_acc = 1'b1;
    push_event();
    @(negedge clk);
    push_event();
    @(negedge clk);
    l1_acc = 1'b0;
    acc();
    drain(2);

    // R5 R6 R7 fill all slots with the stream stalled
    ptag = "R5 fill";
    rmode = 0;
    acc();
    acc();
    chk(busy == 1'b0, "R5 busy low with a slot free", busy, 0);
    acc();
    chk(busy == 1'b1, "R5 busy when all slots taken", busy, 1);
    chk(overflow == 1'b0, "R6 no overflow yet", overflow, 0);
    acc();
    chk(overflow == 1'b1, "R6 overflow on accept while full", overflow, 1);
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b1, "R7 word offered while stalled", out_valid, 1);
    held = out_data;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R7 valid held while stalled", out_valid, 1);
    chk(out_data == held, "R7 data held while stalled", out_data, held);
    drain(2);
    chk(busy == 1'b0, "R5 R7 busy released after drain", busy, 0);
    chk(overflow == 1'b1, "R6 overflow sticky", overflow, 1);

    // R8 rejected latency writes
    ptag = "R8 write during capture";
    acc();
    setlat(3, 1'b0);
    drain(1);
    setlat(0, 1'b0);
    setlat(MAXLAT + 1, 1'b0);
    repeat (30) @(negedge clk);
    ptag = "R8 out of range writes";
    acc();
    drain(1);

    // R9 latency change discards pending events and a same-cycle accept
    ptag = "R9 pending";
    rmode = 0;
    acc();
    acc();
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b1, "R9 events pending before change", out_valid, 1);
    setlat(9, 1'b1);
    chk(out_valid == 1'b0, "R9 out_valid dropped by change", out_valid, 0);
    chk(busy == 1'b0, "R9 busy low after change", busy, 0);
    repeat (12) @(negedge clk);
    chk(out_valid == 1'b0, "R9 same-cycle accept discarded", out_valid, 0);
    repeat (30) @(negedge clk);
    ptag = "R9 after change";
    acc();
    drain(1);

    finish_run();
  end
endmodule